// File: doc/BRIEF.md
# Polled Multi-Link Serial Collector

This block gathers fixed-length serial frames arriving on up to fifteen independent single-wire links. Each link has its own receiver that shifts one bit per clock into a shift register, checks the framing, and parks the finished payload in a one-word holding register with a pending flag. A single round-robin poller spends two clock cycles on each link. If that link has a pending word, the poller copies it into one shared first-word-fall-through FIFO and frees the holding register.

A full scan of fifteen links takes thirty cycles, and the shortest frame takes sixty-six cycles. Every holding register is therefore emptied before the next frame on its link can complete, even when all links run back to back. The FIFO can become full. In that case the poller leaves pending words where they are and raises a sticky overflow flag. A link whose holding register is still occupied when a further frame completes raises its own sticky overrun flag. An almost-full output lets the logic that generates triggers upstream stop issuing new work.

Top module: `link_poll_collector`

## Requirements
- R1: Each serial line idles high. A frame on a line is one low start bit, then 64 payload bits sent most significant bit first, then one stop bit. The line carries one bit per clock. A new start bit may follow the stop bit directly.
- R2: Each frame with a high stop bit yields exactly one FIFO word. Bits 67:64 of the word hold the link index and bits 63:0 hold the payload.
- R3: A frame whose stop bit is low is discarded. It produces no FIFO word and sets no overrun flag.
- R4: The poller visits the links in ascending index order, two cycles per link. A received word reaches the FIFO output within 32 cycles of its stop bit, provided the FIFO is not full.
- R5: All 15 links may send frames at the same time and back to back. No word is lost and no overrun is flagged, and each link's words leave in the order they were sent.
- R6: The FIFO is first-word-fall-through. `rd_en` pops the word shown on `rd_data`. A pop while `fifo_empty` is high has no effect.
- R7: `almost_full` is high exactly while the FIFO holds at least AF_LEVEL words.
- R8: When the poller finds a pending word and the FIFO is full, the word stays in its holding register and is moved once space frees up. `overflow` is set and stays set until reset.
- R9: When a frame with a high stop bit completes while the link still holds an undrained word, the new frame is discarded and the old word is kept. That link's bit of `link_overrun` is set and stays set until reset.
- R10: Synchronous reset empties the FIFO, clears every holding register, and clears `almost_full`, `overflow` and `link_overrun`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | NUM_LINKS | One serial line per link, idle high |
| rd_en | input | 1 | Pop the word currently on rd_data |
| rd_data | output | 68 | FIFO head: link index [67:64], payload [63:0] |
| fifo_empty | output | 1 | FIFO holds no word |
| almost_full | output | 1 | FIFO occupancy at or above AF_LEVEL |
| overflow | output | 1 | Sticky: a pending word met a full FIFO |
| link_overrun | output | NUM_LINKS | Sticky per link: a frame was lost to an occupied holding register |

## Verification
A stuck or mis-sequenced poller index shows up as a word that is missing at the FIFO head 32 cycles after its stop bit. It can also show up as a word carrying the wrong link index. A receiver that miscounts bits shows at the ports as a shifted payload, or as a good frame taken for a bad stop bit, within one frame time. A wrong FIFO pointer or a wrong occupancy count appears as wrong per-link order, a wrong word count when the FIFO is drained, or a misplaced `almost_full` edge. A holding register that fails to clear or fails to hold shows as spurious `link_overrun` bits during back-to-back traffic, or as a lost word after the FIFO has been full.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    localparam int PAY_W  = 64;
    localparam int LINK_W = 4;
    localparam int WORD_W = PAY_W + LINK_W;
    localparam int CNT_W  = $clog2(PAY_W);

    typedef logic [PAY_W-1:0] payload_t;

    typedef struct packed {
        logic [LINK_W-1:0] link;
        payload_t          payload;
    } fifo_word_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_STOP
    } rx_state_e;

    function automatic logic [LINK_W-1:0] next_link(input logic [LINK_W-1:0] cur,
                                                    input int n);
        if (int'(cur) >= n - 1) return '0;
        return cur + 1'b1;
    endfunction

endpackage

// File: rtl/lpc_link_rx.sv
module lpc_link_rx
    import lpc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ser_i,
    input  logic     clr_i,
    output logic     valid_o,
    output payload_t data_o,
    output logic     overrun_o
);

    rx_state_e          state_q;
    logic [CNT_W-1:0]   bit_cnt_q;
    payload_t           shreg_q;
    logic               frame_good;

    assign frame_good = (state_q == RX_STOP) && ser_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= RX_IDLE;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
        end else begin
            case (state_q)
                RX_IDLE: begin
                    bit_cnt_q <= '0;
                    if (!ser_i) state_q <= RX_SHIFT;
                end
                RX_SHIFT: begin
                    shreg_q   <= {shreg_q[PAY_W-2:0], ser_i};
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                    if (bit_cnt_q == CNT_W'(PAY_W - 1)) state_q <= RX_STOP;
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o   <= 1'b0;
            data_o    <= '0;
            overrun_o <= 1'b0;
        end else if (frame_good) begin
            if (valid_o && !clr_i) begin
                overrun_o <= 1'b1;
            end else begin
                data_o  <= shreg_q;
                valid_o <= 1'b1;
            end
        end else if (clr_i) begin
            valid_o <= 1'b0;
        end
    end

    AST_OVERRUN_KEEPS_WORD: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun_o) |-> valid_o); // R9
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun_o |=> overrun_o); // R9
    AST_HOLD_WITHOUT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !clr_i) |=> (valid_o && $stable(data_o))); // R8

endmodule

// File: rtl/lpc_poller.sv
module lpc_poller
    import lpc_pkg::*;
#(
    parameter int NUM_LINKS = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINKS-1:0] valid_i,
    input  payload_t             data_i [NUM_LINKS],
    input  logic                 full_i,
    output logic [NUM_LINKS-1:0] clr_o,
    output logic                 wr_en_o,
    output fifo_word_t           wr_word_o,
    output logic                 overflow_o
);

    logic [LINK_W-1:0] idx_q;
    logic              phase_q;
    logic              pending;
    payload_t          sel_data;

    always_comb begin
        sel_data = '0;
        pending  = 1'b0;
        for (int i = 0; i < NUM_LINKS; i++) begin
            if (int'(idx_q) == i) begin
                sel_data = data_i[i];
                pending  = !phase_q && valid_i[i];
            end
        end
    end

    always_comb begin
        clr_o     = '0;
        wr_en_o   = 1'b0;
        wr_word_o = '{link: idx_q, payload: sel_data};
        if (pending && !full_i) begin
            wr_en_o = 1'b1;
            for (int i = 0; i < NUM_LINKS; i++) begin
                if (int'(idx_q) == i) clr_o[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q      <= '0;
            phase_q    <= 1'b0;
            overflow_o <= 1'b0;
        end else begin
            phase_q <= !phase_q;
            if (phase_q) idx_q <= next_link(idx_q, NUM_LINKS);
            if (pending && full_i) overflow_o <= 1'b1;
        end
    end

    AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_o)); // R4
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o); // R8
    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        full_i |-> !wr_en_o); // R8

endmodule

// File: rtl/lpc_fifo.sv
module lpc_fifo
    import lpc_pkg::*;
#(
    parameter int DEPTH    = 4096,
    parameter int AF_LEVEL = 4000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en_i,
    input  fifo_word_t wr_word_i,
    input  logic       rd_en_i,
    output fifo_word_t rd_word_o,
    output logic       empty_o,
    output logic       full_o,
    output logic       almost_full_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    fifo_word_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] rd_ptr_q;
    logic [CW-1:0] count_q;
    logic          do_wr;
    logic          do_rd;

    assign empty_o       = (count_q == '0);
    assign full_o        = (count_q == CW'(DEPTH));
    assign almost_full_o = (count_q >= CW'(AF_LEVEL));
    assign do_wr         = wr_en_i && !full_o;
    assign do_rd         = rd_en_i && !empty_o;
    assign rd_word_o     = mem[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr_q] <= wr_word_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_wr) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (do_rd) rd_ptr_q <= rd_ptr_q + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |-> (count_q < CW'(DEPTH))); // R8
    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && empty_o && !wr_en_i) |=> empty_o); // R6
    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(DEPTH)); // R7

endmodule

// File: rtl/link_poll_collector.sv
module link_poll_collector #(
    parameter int NUM_LINKS  = 15,
    parameter int FIFO_DEPTH = 4096,
    parameter int AF_LEVEL   = 4000
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_LINKS-1:0]        ser_in,
    input  logic                        rd_en,
    output logic [lpc_pkg::WORD_W-1:0]  rd_data,
    output logic                        fifo_empty,
    output logic                        almost_full,
    output logic                        overflow,
    output logic [NUM_LINKS-1:0]        link_overrun
);
    import lpc_pkg::*;

    logic [NUM_LINKS-1:0] valid;
    logic [NUM_LINKS-1:0] clr;
    payload_t             hold_data [NUM_LINKS];
    logic                 wr_en;
    fifo_word_t           wr_word;
    fifo_word_t           head;
    logic                 full;

    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
        lpc_link_rx u_rx (
            .clk       (clk),
            .rst       (rst),
            .ser_i     (ser_in[g]),
            .clr_i     (clr[g]),
            .valid_o   (valid[g]),
            .data_o    (hold_data[g]),
            .overrun_o (link_overrun[g])
        );
    end

    lpc_poller #(.NUM_LINKS(NUM_LINKS)) u_poll (
        .clk        (clk),
        .rst        (rst),
        .valid_i    (valid),
        .data_i     (hold_data),
        .full_i     (full),
        .clr_o      (clr),
        .wr_en_o    (wr_en),
        .wr_word_o  (wr_word),
        .overflow_o (overflow)
    );

    lpc_fifo #(.DEPTH(FIFO_DEPTH), .AF_LEVEL(AF_LEVEL)) u_fifo (
        .clk           (clk),
        .rst           (rst),
        .wr_en_i       (wr_en),
        .wr_word_i     (wr_word),
        .rd_en_i       (rd_en),
        .rd_word_o     (head),
        .empty_o       (fifo_empty),
        .full_o        (full),
        .almost_full_o (almost_full)
    );

    assign rd_data = head;

    initial begin
        assert (NUM_LINKS >= 1 && NUM_LINKS <= 16); // R2
    end

endmodule

// File: tb/link_poll_collector_tb.sv
module link_poll_collector_tb;
    import lpc_pkg::*;

    localparam int NL = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] ser_in = '1;
    logic          rd_en = 1'b0;
    logic [WORD_W-1:0] rd_data;
    logic          fifo_empty, almost_full, overflow;
    logic [NL-1:0] link_overrun;

    int checks = 0;
    int fails  = 0;
    int tx_round [NL];
    int exp_round [NL];

    always #5 clk = ~clk;

    link_poll_collector #(.NUM_LINKS(NL), .FIFO_DEPTH(32), .AF_LEVEL(24)) u_dut (
        .clk(clk), .rst(rst), .ser_in(ser_in), .rd_en(rd_en), .rd_data(rd_data),
        .fifo_empty(fifo_empty), .almost_full(almost_full), .overflow(overflow),
        .link_overrun(link_overrun)
    );

    // {link[4:1], stop bit[0]}
    localparam logic [4:0] VEC [6] = '{
        {4'd0, 1'b1}, {4'd14, 1'b1}, {4'd7, 1'b0},
        {4'd7, 1'b1}, {4'd3, 1'b1}, {4'd3, 1'b1}
    };

    function automatic payload_t mkpay(input int l, input int r);
        return {8'(l), 8'(r), 48'h5A5A_C3C3_0F0F} ^ {32'(r * 977), 32'(l * 131 + 7)};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [NL-1:0] mask, input logic stop_bit, input bit keep);
        payload_t pay [NL];
        for (int l = 0; l < NL; l++) pay[l] = keep ? mkpay(l, tx_round[l]) : mkpay(l, 238);
        for (int b = 0; b < 66; b++) begin
            @(negedge clk);
            for (int l = 0; l < NL; l++) begin
                if (mask[l]) ser_in[l] = (b == 0) ? 1'b0 : (b <= 64) ? pay[l][64-b] : stop_bit;
            end
        end
        @(negedge clk);
        ser_in = '1;
        if (keep && stop_bit)
            for (int l = 0; l < NL; l++) if (mask[l]) tx_round[l]++;
    endtask

    task automatic pop_check(input string req);
        fifo_word_t w;
        w = fifo_word_t'(rd_data);
        if (fifo_empty) begin
            chk(1'b0, req, '0, 68'h1);
        end else if (int'(w.link) >= NL) begin
            chk(1'b0, req, rd_data, '0);
        end else begin
            chk(w.payload == mkpay(int'(w.link), exp_round[w.link]), req,
                rd_data, {w.link, mkpay(int'(w.link), exp_round[w.link])});
            exp_round[w.link]++;
        end
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int drained;
        for (int l = 0; l < NL; l++) begin
            tx_round[l] = 0;
            exp_round[l] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk(fifo_empty && !almost_full && !overflow && link_overrun == '0, "R10",
            {fifo_empty, almost_full, overflow, NL'(link_overrun)}, {1'b1, 2'b0, NL'(0)});

        // Table walk: single-link frames, good and bad stop bits (R1 R2 R3 R4)
        for (int i = 0; i < 6; i++) begin
            send(NL'(1) << VEC[i][4:1], VEC[i][0], 1'b1);
            repeat (31) @(negedge clk);
            if (VEC[i][0]) begin
                chk(!fifo_empty, "R4", 68'(fifo_empty), 68'h0);
                pop_check("R1 R2");
                chk(fifo_empty, "R2", 68'(fifo_empty), 68'h1);
            end else begin
                chk(fifo_empty, "R3", 68'(fifo_empty), 68'h1);
                chk(link_overrun == '0, "R3", 68'(link_overrun), 68'h0);
            end
        end

        // R6: pop on empty FIFO has no effect
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(fifo_empty, "R6", 68'(fifo_empty), 68'h1);

        // R5: all links, two frames back to back
        send('1, 1'b1, 1'b1);
        send('1, 1'b1, 1'b1);
        repeat (32) @(negedge clk);
        chk(link_overrun == '0, "R5", 68'(link_overrun), 68'h0);
        chk(almost_full, "R7", 68'(almost_full), 68'h1);
        chk(!overflow, "R8", 68'(overflow), 68'h0);

        // Fill to exactly full: 32 words
        send(NL'(3), 1'b1, 1'b1);
        repeat (32) @(negedge clk);
        chk(!overflow, "R8", 68'(overflow), 68'h0);

        // R8: word held while FIFO full
        send(NL'(4), 1'b1, 1'b1);
        repeat (32) @(negedge clk);
        chk(overflow, "R8", 68'(overflow), 68'h1);

        // R9: another frame on link 2 while its word is still held
        send(NL'(4), 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        chk(link_overrun == NL'(4), "R9", 68'(link_overrun), 68'h4);

        // Drain everything: 32 stored plus the held link-2 word
        drained = 0;
        while (!fifo_empty && drained < 40) begin
            pop_check("R5");
            drained++;
            repeat (2) @(negedge clk);
            if (fifo_empty) repeat (34) @(negedge clk);
        end
        chk(drained == 33, "R8", 68'(drained), 68'd33);
        chk(!almost_full, "R7", 68'(almost_full), 68'h0);
        chk(overflow, "R8", 68'(overflow), 68'h1);
        for (int l = 0; l < NL; l++)
            chk(exp_round[l] == tx_round[l], "R9", 68'(exp_round[l]), 68'(tx_round[l]));

        // R10: reset clears sticky flags
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(!overflow && link_overrun == '0 && fifo_empty, "R10",
            {overflow, NL'(link_overrun), fifo_empty}, {1'b0, NL'(0), 1'b1});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule